// File: doc/BRIEF.md
# NAND flash bus cycle generator

This block produces the pin-level signalling for single NAND flash bus cycles: a command latch, an address latch, a data write or a data read. A requester presents one cycle at a time on a valid/ready interface, naming the cycle kind, which of two devices is addressed, and the byte or word to send. The block then runs chip enable, the command and address latch enables, the write and read strobes and the data bus through a fixed sequence of phases, and for a read returns the word captured from the bus.

All phase lengths are counted in half periods of the flash timing period T, where a half period is `HALF_CYC` controller clock cycles, so the whole block runs on one clock. A mode bit, taken with each request, selects slow-strobe timing (strobes of a whole period, long chip-enable setup and hold) or fast-strobe timing (strobes of half a period, hold of one and a half periods). The ready/busy line from the flash is synchronised and gates the start of read cycles only.

Top module: `nand_cycle_gen`

## Requirements
- R1: While and after a synchronous reset with no request, both chip enables are high, both latch enables are low, both strobes are high, the bus is not driven, `req_ready` is 1 and `rsp_valid` is 0.
- R2: `req_kind` encodes 0 = command, 1 = address, 2 = write data, 3 = read data. A command cycle holds `nf_cle` high and `nf_ale` low, an address cycle the reverse, and data cycles keep both low; the latch enable is high from the acceptance edge to the end of the hold phase.
- R3: With `req_sym` = 0 the phases last, in half periods of `HALF_CYC` clocks each: setup 2, strobe 2, hold 2, tail 4, all starting at the acceptance edge, so chip enable stays low 6 half periods after the strobe rises.
- R4: With `req_sym` = 1 the phases last: setup 1, strobe 1, hold 2, tail 1, so the strobe is half a period low and chip enable stays low 3 half periods after it rises.
- R5: The timing mode is taken at the acceptance edge; changing `req_sym` while a cycle runs does not change that cycle.
- R6: Only the enable selected by `req_cs` goes low (`req_cs` = 0 drives bit 0, 1 drives bit 1), from the acceptance edge to the end of the tail phase.
- R7: Command, address and write cycles pulse `nf_we_n` low during the strobe phase, keep `nf_re_n` high and drive the bus from setup to the end of hold; command and address send `req_data[7:0]` with all upper bits zero, write sends the full word.
- R8: A read cycle pulses `nf_re_n` low during the strobe phase, keeps `nf_we_n` high and never drives the bus; the word on `nf_dq_i` at the clock edge that ends the strobe is returned on `rsp_data`.
- R9: `nf_rb` passes through a two-stage synchroniser. A read accepted while it reads low leaves all pins idle and starts its setup phase two edges after the first edge that samples `nf_rb` high; command, address and write cycles start at acceptance whatever `nf_rb` is.
- R10: `req_ready` is 1 only while idle; a request is accepted on an edge where `req_valid` and `req_ready` are both 1, and a new request can be accepted on the edge right after a cycle ends.
- R11: `rsp_valid` is a one-cycle pulse in the first idle cycle after a read and is never raised after other cycle kinds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_kind | input | 2 | Cycle kind (R2 encoding) |
| req_cs | input | 1 | Device select |
| req_data | input | DW | Command, address byte or write word |
| req_sym | input | 1 | 1 = half-period strobe timing |
| rsp_valid | output | 1 | Read word available |
| rsp_data | output | DW | Captured read word |
| nf_ce_n | output | 2 | Chip enables, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_o | output | DW | Bus output value |
| nf_dq_oe | output | 1 | Bus output enable |
| nf_dq_i | input | DW | Bus input value |
| nf_rb | input | 1 | Ready (1) / busy (0) from flash |

## Verification
The bench builds the block with a 16-bit bus and three clocks per half period. The wide bus makes the zeroed upper byte of command and address cycles visible next to full-word writes, and an odd half-period length puts every phase boundary off a power-of-two count, so an off-by-one in the half-period divider or in any phase length shows as a strobe or enable edge one clock out of place in the cycle-by-cycle comparison.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

  typedef enum logic [1:0] {
    NFC_CMD   = 2'd0,
    NFC_ADDR  = 2'd1,
    NFC_WRITE = 2'd2,
    NFC_READ  = 2'd3
  } nfc_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WAIT   = 3'd1,
    ST_SETUP  = 3'd2,
    ST_STROBE = 3'd3,
    ST_HOLD   = 3'd4,
    ST_TAIL   = 3'd5
  } nfc_state_e;

  function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                          input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/nfc_rb_sync.sv
module nfc_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rb_async,
  output logic rb_sync
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= {q[STAGES-2:0], rb_async};
  end

  assign rb_sync = q[STAGES-1];
endmodule

// File: rtl/nfc_phase_timer.sv
module nfc_phase_timer #(
  parameter int HALF_CYC = 2,
  parameter int LENW     = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [LENW-1:0] start_len,
  output logic            done
);
  localparam int SUBW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic            half_tick;
  logic [LENW-1:0] left_q;

  generate
    if (HALF_CYC == 1) begin : g_full
      assign half_tick = 1'b1;
    end else begin : g_div
      logic [SUBW-1:0] sub_q;
      always_ff @(posedge clk) begin
        if (rst || start)                      sub_q <= '0;
        else if (sub_q == SUBW'(HALF_CYC - 1)) sub_q <= '0;
        else                                   sub_q <= sub_q + 1'b1;
      end
      assign half_tick = (sub_q == SUBW'(HALF_CYC - 1));

      // R3
      sub_range_chk: assert property (@(posedge clk) disable iff (rst)
        sub_q <= SUBW'(HALF_CYC - 1));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                             left_q <= '0;
    else if (start)                      left_q <= start_len;
    else if (half_tick && left_q != '0)  left_q <= left_q - 1'b1;
  end

  assign done = half_tick && (left_q == '0);
endmodule

// File: rtl/nand_cycle_gen.sv
module nand_cycle_gen
  import nfc_pkg::*;
#(
  parameter int DW        = 16,
  parameter int HALF_CYC  = 2,
  parameter int RB_STAGES = 2,
  parameter int A_SETUP   = 2,
  parameter int A_STROBE  = 2,
  parameter int A_HOLD    = 2,
  parameter int A_TAIL    = 4,
  parameter int S_SETUP   = 1,
  parameter int S_STROBE  = 1,
  parameter int S_HOLD    = 2,
  parameter int S_TAIL    = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic          req_cs,
  input  logic [DW-1:0] req_data,
  input  logic          req_sym,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic [1:0]    nf_ce_n,
  output logic          nf_cle,
  output logic          nf_ale,
  output logic          nf_we_n,
  output logic          nf_re_n,
  output logic [DW-1:0] nf_dq_o,
  output logic          nf_dq_oe,
  input  logic [DW-1:0] nf_dq_i,
  input  logic          nf_rb
);
  localparam int MAXH = max_of4(max_of4(A_SETUP, A_STROBE, A_HOLD, A_TAIL),
                                S_SETUP, S_STROBE, max_of4(S_HOLD, S_TAIL, 1, 1));
  localparam int LENW = $clog2(MAXH + 1);

  nfc_state_e    st_q, st_n;
  nfc_kind_e     kind_q, kind_n;
  logic          cs_q, cs_n;
  logic [DW-1:0] data_q, data_n;
  logic          sym_q, sym_n;
  logic          rb_s;
  logic          phase_start;
  logic          phase_done;
  logic          active_n, latch_n, drive_n;

  function automatic logic [LENW-1:0] len_m1(input nfc_state_e ph, input logic sym);
    int unsigned v;
    case (ph)
      ST_SETUP:  v = sym ? S_SETUP  : A_SETUP;
      ST_STROBE: v = sym ? S_STROBE : A_STROBE;
      ST_HOLD:   v = sym ? S_HOLD   : A_HOLD;
      ST_TAIL:   v = sym ? S_TAIL   : A_TAIL;
      default:   v = 1;
    endcase
    return LENW'(v - 1);
  endfunction

  nfc_rb_sync #(.STAGES(RB_STAGES)) i_rb_sync (
    .clk(clk), .rst(rst), .rb_async(nf_rb), .rb_sync(rb_s)
  );

  nfc_phase_timer #(.HALF_CYC(HALF_CYC), .LENW(LENW)) i_timer (
    .clk(clk), .rst(rst), .start(phase_start),
    .start_len(len_m1(st_n, sym_n)), .done(phase_done)
  );

  always_comb begin
    st_n   = st_q;
    kind_n = kind_q;
    cs_n   = cs_q;
    data_n = data_q;
    sym_n  = sym_q;
    case (st_q)
      ST_IDLE: if (req_valid) begin
        kind_n = nfc_kind_e'(req_kind);
        cs_n   = req_cs;
        data_n = req_data;
        sym_n  = req_sym;
        st_n   = (kind_n == NFC_READ && !rb_s) ? ST_WAIT : ST_SETUP;
      end
      ST_WAIT:   if (rb_s)       st_n = ST_SETUP;
      ST_SETUP:  if (phase_done) st_n = ST_STROBE;
      ST_STROBE: if (phase_done) st_n = ST_HOLD;
      ST_HOLD:   if (phase_done) st_n = ST_TAIL;
      ST_TAIL:   if (phase_done) st_n = ST_IDLE;
      default:                   st_n = ST_IDLE;
    endcase
    active_n    = st_n inside {ST_SETUP, ST_STROBE, ST_HOLD, ST_TAIL};
    latch_n     = st_n inside {ST_SETUP, ST_STROBE, ST_HOLD};
    drive_n     = latch_n && (kind_n != NFC_READ);
    phase_start = active_n && (st_n != st_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      kind_q <= NFC_CMD;
      cs_q   <= 1'b0;
      data_q <= '0;
      sym_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      kind_q <= kind_n;
      cs_q   <= cs_n;
      data_q <= data_n;
      sym_q  <= sym_n;
    end
  end

  // Registered pin drivers, computed from the next state
  always_ff @(posedge clk) begin
    if (rst) begin
      nf_ce_n  <= 2'b11;
      nf_cle   <= 1'b0;
      nf_ale   <= 1'b0;
      nf_we_n  <= 1'b1;
      nf_re_n  <= 1'b1;
      nf_dq_oe <= 1'b0;
      nf_dq_o  <= '0;
    end else begin
      nf_ce_n <= 2'b11;
      if (active_n) nf_ce_n[cs_n] <= 1'b0;
      nf_cle   <= latch_n && (kind_n == NFC_CMD);
      nf_ale   <= latch_n && (kind_n == NFC_ADDR);
      nf_we_n  <= !(st_n == ST_STROBE && kind_n != NFC_READ);
      nf_re_n  <= !(st_n == ST_STROBE && kind_n == NFC_READ);
      nf_dq_oe <= drive_n;
      if (!drive_n)                nf_dq_o <= '0;
      else if (kind_n == NFC_WRITE) nf_dq_o <= data_n;
      else                          nf_dq_o <= DW'(data_n[7:0]);
    end
  end

  // Read capture at the edge that ends the read strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_data  <= '0;
      rsp_valid <= 1'b0;
    end else begin
      if (st_q == ST_STROBE && phase_done && kind_q == NFC_READ) rsp_data <= nf_dq_i;
      rsp_valid <= (st_q == ST_TAIL) && phase_done && (kind_q == NFC_READ);
    end
  end

  assign req_ready = (st_q == ST_IDLE);

  // R6
  ce_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(~nf_ce_n) <= 1);
  // R2
  latch_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(nf_cle && nf_ale));
  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    nf_we_n || nf_re_n);
  // R8
  read_float_chk: assert property (@(posedge clk) disable iff (rst)
    !nf_re_n |-> !nf_dq_oe);
  // R3
  strobe_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (!nf_we_n || !nf_re_n) |-> !(&nf_ce_n));
  // R9
  wait_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAIT) |-> (&nf_ce_n && nf_re_n && !nf_dq_oe));
  // R11
  rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> req_ready);
  // R5
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_IDLE) |=> $stable(sym_q));
endmodule

// File: tb/test_nand_cycle_gen.sv
module test_nand_cycle_gen;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int HC = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_kind = 2'd0;
  logic          req_cs = 1'b0;
  logic [DW-1:0] req_data = '0;
  logic          req_sym = 1'b0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic [1:0]    nf_ce_n;
  logic          nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
  logic [DW-1:0] nf_dq_o;
  logic [DW-1:0] nf_dq_i;
  logic          nf_rb = 1'b1;
  logic [DW-1:0] dev_word = '0;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Flash model: drives the word only while the read strobe is low
  assign nf_dq_i = nf_re_n ? '1 : dev_word;

  nand_cycle_gen #(.DW(DW), .HALF_CYC(HC)) i_nand_cycle_gen (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_cs(req_cs), .req_data(req_data), .req_sym(req_sym),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .nf_ce_n(nf_ce_n), .nf_cle(nf_cle),
    .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_dq_o(nf_dq_o),
    .nf_dq_oe(nf_dq_oe), .nf_dq_i(nf_dq_i), .nf_rb(nf_rb)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  task automatic check_idle(input string req, input bit ready_exp);
    chk(nf_ce_n == 2'b11, req, nf_ce_n, 2'b11);
    chk({nf_cle, nf_ale} == 2'b00, req, {nf_cle, nf_ale}, 2'b00);
    chk({nf_we_n, nf_re_n} == 2'b11, req, {nf_we_n, nf_re_n}, 2'b11);
    chk(nf_dq_oe == 1'b0, req, nf_dq_oe, 0);
    chk(req_ready == ready_exp, req, req_ready, ready_exp);
  endtask

  // Called at a negedge; returns at the negedge after the cycle has ended.
  task automatic run_op(input int kind, input int cs, input logic [DW-1:0] data,
                        input bit sym, input int wait_n, input bit flip,
                        input logic [DW-1:0] word);
    int s, p, h, t, total, hv;
    bit strobe, latch;
    logic [1:0] ce_exp;
    logic [DW-1:0] dq_exp;
    string treq;
    s = sym ? 1 : 2;  p = sym ? 1 : 2;  h = 2;  t = sym ? 1 : 4;
    total = (s + p + h + t) * HC;
    treq = sym ? "R4" : "R3";
    dev_word = word;
    chk(req_ready == 1'b1, "R10", req_ready, 1);
    req_valid = 1'b1; req_kind = kind[1:0]; req_cs = cs[0]; req_data = data; req_sym = sym;
    @(negedge clk);
    req_valid = 1'b0; req_data = '0;
    if (wait_n > 0) begin
      for (int i = 0; i < wait_n + 3; i++) begin
        check_idle("R9", 1'b0);
        if (i == wait_n) nf_rb = 1'b1;
        @(negedge clk);
      end
    end
    for (int k = 0; k < total; k++) begin
      if (flip && k == 1) req_sym = !sym;
      hv = k / HC;
      latch  = hv < s + p + h;
      strobe = (hv >= s) && (hv < s + p);
      ce_exp = ~(2'b01 << cs);
      chk(nf_ce_n == ce_exp, "R6", nf_ce_n, ce_exp);
      chk(nf_cle == (kind == 0 && latch), "R2", nf_cle, (kind == 0 && latch));
      chk(nf_ale == (kind == 1 && latch), "R2", nf_ale, (kind == 1 && latch));
      chk(nf_we_n == !(strobe && kind != 3), flip ? "R5" : treq, nf_we_n, !(strobe && kind != 3));
      chk(nf_re_n == !(strobe && kind == 3), kind == 3 ? "R8" : treq, nf_re_n, !(strobe && kind == 3));
      chk(nf_dq_oe == (kind != 3 && latch), "R7", nf_dq_oe, (kind != 3 && latch));
      if (kind != 3 && latch) begin
        dq_exp = (kind == 2) ? data : {8'h00, data[7:0]};
        chk(nf_dq_o == dq_exp, "R7", nf_dq_o, dq_exp);
      end
      chk(req_ready == 1'b0, "R10", req_ready, 0);
      chk(rsp_valid == 1'b0, "R11", rsp_valid, 0);
      @(negedge clk);
    end
    check_idle("R10", 1'b1);
    chk(rsp_valid == (kind == 3), "R11", rsp_valid, (kind == 3));
    if (kind == 3) chk(rsp_data == word, "R8", rsp_data, word);
    req_sym = sym;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1", 1'b1);
    chk(rsp_valid == 1'b0, "R1", rsp_valid, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check_idle("R1", 1'b1);

    // Slow-strobe timing, each kind, both devices
    run_op(0, 0, 16'hA570, 1'b0, 0, 1'b0, '0);
    run_op(1, 1, 16'h5A3C, 1'b0, 0, 1'b0, '0);
    run_op(2, 0, 16'hBEEF, 1'b0, 0, 1'b0, '0);
    run_op(3, 1, 16'h0000, 1'b0, 0, 1'b0, 16'h1234);
    // Fast-strobe timing, back to back
    run_op(0, 1, 16'hFF90, 1'b1, 0, 1'b0, '0);
    run_op(2, 1, 16'hC3A5, 1'b1, 0, 1'b0, '0);
    run_op(3, 0, 16'h0000, 1'b1, 0, 1'b0, 16'h8E71);
    run_op(1, 0, 16'h12F0, 1'b1, 0, 1'b0, '0);
    // R5: mode change during a running cycle is ignored
    run_op(2, 0, 16'h6006, 1'b0, 0, 1'b1, '0);
    run_op(3, 1, 16'h0000, 1'b1, 0, 1'b1, 16'hA5A5);
    // R9: busy device; command starts at once, read waits
    nf_rb = 1'b0;
    for (int i = 0; i < 3; i++) begin
      check_idle("R9", 1'b1);
      @(negedge clk);
    end
    run_op(0, 0, 16'h0070, 1'b0, 0, 1'b0, '0);
    nf_rb = 1'b0;
    @(negedge clk);
    @(negedge clk);
    run_op(3, 0, 16'h0000, 1'b0, 5, 1'b0, 16'h4C2D);
    nf_rb = 1'b0;
    @(negedge clk);
    @(negedge clk);
    run_op(3, 1, 16'h0000, 1'b1, 1, 1'b0, 16'hF00F);
    @(negedge clk);
    check_idle("R11", 1'b1);
    chk(rsp_valid == 1'b0, "R11", rsp_valid, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule